// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Output Formatter

This block takes decoded 4:2:2 video, one pixel per accepted input strobe, and places it on an output port. Each input pixel carries a luma byte, a Cb byte, a Cr byte, an active-region flag and a line-start marker. Every output is registered on the single clock. The outputs are a data-valid qualifier, an ACTIVE flag and two byte buses.

A mode input picks one of two formats, and the block samples it only at line starts.

In wide mode, each accepted pixel produces one output cycle. Luma goes on `out_y` and chroma on `out_c`. The chroma alternates Cb, Cr, Cb, Cr, starting from Cb at the line-start pixel. Blanking pixels are presented as well, and ACTIVE follows the pixel's active flag.

In narrow mode, each active pixel produces two consecutive bytes on `out_y`: its chroma byte first, then its luma byte. This gives the stream Cb0, Y0, Cr0, Y1, Cb2 and so on. While the second byte is pending, the input is stalled by dropping `in_ready`. Blanking pixels are accepted but produce nothing, and ACTIVE stays high.

Upstream valid strobes may arrive with any irregular spacing. The sequence advances only on accepted pixels.

Top module: `yuv422_out_fmt`

## Requirements
- R1: After a synchronous reset, `out_dv` and `out_active` are 0, `in_ready` is 1 and the format is wide.
- R2: In wide mode, a pixel accepted at a clock edge sets `out_dv` to 1 after that edge, with `out_y` equal to its luma and `out_active` equal to its `in_active`. This holds for active and blanking pixels alike.
- R3: In wide mode, `out_c` carries Cb for the line-start pixel and then alternates Cr, Cb, and so on, on each accepted pixel. The alternation continues through blanking pixels.
- R4: In narrow mode, an accepted active pixel yields two consecutive output cycles with `out_dv`=1 on `out_y`. The first carries the chroma byte, which is Cb at the line start and then alternates Cr/Cb per pixel. The second carries the luma byte.
- R5: In narrow mode, an accepted pixel with `in_active`=0 produces no output cycle (`out_dv` stays 0).
- R6: While the narrow format is in effect, `out_active` is 1, blanking included.
- R7: After an active pixel is accepted in narrow mode, `in_ready` is 0 for exactly one cycle.
- R8: When `out_dv` is 0, `out_y` and `out_c` keep their values. In narrow mode `out_c` is never updated.
- R9: A cycle with no accepted pixel and no pending byte gives `out_dv`=0 and does not advance the chroma phase.
- R10: `mode_sel` (1 = narrow, 0 = wide) is sampled only on an accepted pixel with `in_sol`=1. That pixel and all following pixels use the sampled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Format request: 1 narrow (8-bit), 0 wide (16-bit) |
| in_valid | input | 1 | Input pixel strobe |
| in_ready | output | 1 | Input may be accepted this cycle |
| in_active | input | 1 | Pixel lies in the active region |
| in_sol | input | 1 | Pixel is the first active pixel of a line |
| in_y | input | 8 | Luma |
| in_cb | input | 8 | Cb sample |
| in_cr | input | 8 | Cr sample |
| out_dv | output | 1 | Output data valid |
| out_active | output | 1 | Active-region flag |
| out_y | output | 8 | Luma bus (wide) or interleaved bus (narrow) |
| out_c | output | 8 | Chroma bus (wide only) |

## Verification
The assertions check several rules on every cycle:
- bus hold while `out_dv` is low;
- the one-cycle stall after a narrow pixel;
- the luma byte following each narrow chroma byte;
- silence for narrow blanking pixels and idle cycles;
- the wide luma pass-through;
- ACTIVE staying high in narrow mode;
- the mode register changing only at line starts.

The exact byte order, the Cb-first restart at each line, the chroma alternation across gaps and blanking, and a mode request that waits for the next line start are shown only by the bench's directed scenarios.

// File: rtl/yuv422_out_fmt.sv
module yuv422_out_fmt (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_active,
  input  logic       in_sol,
  input  logic [7:0] in_y,
  input  logic [7:0] in_cb,
  input  logic [7:0] in_cr,
  output logic       out_dv,
  output logic       out_active,
  output logic [7:0] out_y,
  output logic [7:0] out_c
);
  logic       mode_q, phase, pend;
  logic [7:0] y_hold;

  wire       take   = in_valid && in_ready;
  wire       narrow = in_sol ? mode_sel : mode_q;
  wire       ph     = in_sol ? 1'b0 : phase;
  wire [7:0] chroma = ph ? in_cr : in_cb;

  assign in_ready = !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 1'b0;
      phase      <= 1'b0;
      pend       <= 1'b0;
      out_dv     <= 1'b0;
      out_active <= 1'b0;
    end else begin
      out_dv <= 1'b0;
      if (pend) begin
        out_y  <= y_hold;
        out_dv <= 1'b1;
        pend   <= 1'b0;
      end else if (take) begin
        mode_q <= narrow;
        phase  <= !ph;
        if (narrow) begin
          out_active <= 1'b1;
          if (in_active) begin
            out_y  <= chroma;
            y_hold <= in_y;
            pend   <= 1'b1;
            out_dv <= 1'b1;
          end
        end else begin
          out_y      <= in_y;
          out_c      <= chroma;
          out_active <= in_active;
          out_dv     <= 1'b1;
        end
      end
    end
  end
endmodule

module yuv422_out_fmt_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_sel,
  input logic       mode_q,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_active,
  input logic       in_sol,
  input logic [7:0] in_y,
  input logic       out_dv,
  input logic       out_active,
  input logic [7:0] out_y,
  input logic [7:0] out_c
);
  wire acc  = in_valid && in_ready;
  wire nar  = in_sol ? mode_sel : mode_q;

  AST_WIDE_PASS: assert property (@(posedge clk) disable iff (rst)
    acc && !nar |=> out_dv && out_y == $past(in_y)); // R2
  AST_LUMA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc && nar && in_active |=> out_dv && !in_ready); // R4
  AST_NARROW_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    acc && nar && !in_active |=> !out_dv); // R5
  AST_NARROW_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> out_active); // R6
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready); // R7
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_dv |-> $stable(out_y) && $stable(out_c)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_ready && !in_valid |=> !out_dv); // R9
  AST_MODE_AT_SOL: assert property (@(posedge clk) disable iff (rst)
    !(acc && in_sol) |=> mode_q == $past(mode_q)); // R10
endmodule

bind yuv422_out_fmt yuv422_out_fmt_chk u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .mode_q(mode_q),
  .in_valid(in_valid), .in_ready(in_ready), .in_active(in_active),
  .in_sol(in_sol), .in_y(in_y), .out_dv(out_dv), .out_active(out_active),
  .out_y(out_y), .out_c(out_c)
);

// File: tb/yuv422_out_fmt_test.sv
module yuv422_out_fmt_test;
  logic clk = 0, rst = 1, mode_sel = 0, in_valid = 0, in_active = 0, in_sol = 0;
  logic [7:0] in_y = 0, in_cb = 0, in_cr = 0;
  logic in_ready, out_dv, out_active;
  logic [7:0] out_y, out_c;
  int n_chk = 0, n_fail = 0;
  logic [7:0] qy[$], qc[$];
  logic       qa[$];

  yuv422_out_fmt uut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) if (!rst && out_dv) begin
    qy.push_back(out_y); qc.push_back(out_c); qa.push_back(out_active);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearq; qy.delete(); qc.delete(); qa.delete(); endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic pix(input logic [7:0] y, cb, cr, input logic act, sol);
    while (!in_ready) @(negedge clk);
    in_y = y; in_cb = cb; in_cr = cr; in_active = act; in_sol = sol; in_valid = 1;
    @(negedge clk);
    in_valid = 0; in_sol = 0;
  endtask

  task automatic t_reset;
    rst = 1; idle(3);
    check(out_dv == 0, "R1 dv", out_dv, 0);
    check(out_active == 0, "R1 active", out_active, 0);
    check(in_ready == 1, "R1 ready", in_ready, 1);
    rst = 0; idle(1);
    clearq();
    pix(8'h10, 8'hB0, 8'hC0, 1, 1);
    idle(2);
    check(qy.size() == 1 && qy[0] == 8'h10, "R1 wide after reset", qy.size(), 1);
  endtask

  task automatic t_wide;
    logic [7:0] ey[6] = '{8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26};
    logic [7:0] ec[6] = '{8'hB1, 8'hC2, 8'hB3, 8'hC4, 8'hB5, 8'hC6};
    logic       ea[6] = '{1, 1, 1, 1, 0, 0};
    clearq(); mode_sel = 0;
    pix(8'h21, 8'hB1, 8'hC1, 1, 1);
    pix(8'h22, 8'hB2, 8'hC2, 1, 0);
    idle(3);
    pix(8'h23, 8'hB3, 8'hC3, 1, 0);
    idle(1);
    pix(8'h24, 8'hB4, 8'hC4, 1, 0);
    pix(8'h25, 8'hB5, 8'hC5, 0, 0);
    idle(2);
    pix(8'h26, 8'hB6, 8'hC6, 0, 0);
    idle(3);
    check(qy.size() == 6, "R2 count", qy.size(), 6);
    for (int i = 0; i < 6 && i < qy.size(); i++) begin
      check(qy[i] == ey[i], "R2 luma", qy[i], ey[i]);
      check(qc[i] == ec[i], "R3/R9 chroma", qc[i], ec[i]);
      check(qa[i] == ea[i], "R2 active", qa[i], ea[i]);
    end
    check(out_y == 8'h26 && out_c == 8'hC6, "R8 hold wide", {out_y, out_c}, 16'h26C6);
  endtask

  task automatic t_mode_mid;
    clearq(); mode_sel = 1;
    pix(8'h31, 8'hB7, 8'hC7, 1, 0);
    idle(2);
    check(qy.size() == 1, "R10 no switch mid line", qy.size(), 1);
    if (qy.size() > 0) check(qc[0] == 8'hB7, "R10 wide chroma", qc[0], 8'hB7);
  endtask

  task automatic t_narrow;
    logic [7:0] e[8] = '{8'hB1, 8'h41, 8'hC2, 8'h42, 8'hB3, 8'h43, 8'hC4, 8'h44};
    logic [7:0] c_before;
    c_before = out_c;
    clearq(); mode_sel = 1;
    pix(8'h41, 8'hB1, 8'hC1, 1, 1);
    check(in_ready == 0, "R7 stall", in_ready, 0);
    idle(1);
    check(in_ready == 1, "R7 release", in_ready, 1);
    pix(8'h42, 8'hB2, 8'hC2, 1, 0);
    idle(4);
    pix(8'h43, 8'hB3, 8'hC3, 1, 0);
    pix(8'h44, 8'hB4, 8'hC4, 1, 0);
    idle(2);
    pix(8'h45, 8'hB5, 8'hC5, 0, 0);
    pix(8'h46, 8'hB6, 8'hC6, 0, 0);
    idle(3);
    check(qy.size() == 8, "R4/R5 byte count", qy.size(), 8);
    for (int i = 0; i < 8 && i < qy.size(); i++)
      check(qy[i] == e[i], "R4 byte order", qy[i], e[i]);
    for (int i = 0; i < qa.size(); i++)
      check(qa[i] == 1, "R6 active in narrow", qa[i], 1);
    check(out_active == 1, "R6 active in blanking", out_active, 1);
    check(out_dv == 0, "R5 blanking quiet", out_dv, 0);
    check(out_c == c_before, "R8 chroma bus held", out_c, c_before);
  endtask

  task automatic t_back_wide;
    clearq(); mode_sel = 0;
    pix(8'h51, 8'hB8, 8'hC8, 1, 1);
    pix(8'h52, 8'hB9, 8'hC9, 0, 0);
    idle(2);
    check(qy.size() == 2, "R10 wide at new line", qy.size(), 2);
    if (qy.size() == 2) begin
      check(qy[0] == 8'h51 && qc[0] == 8'hB8, "R3 Cb at line start", {qy[0], qc[0]}, 16'h51B8);
      check(qa[1] == 0 && qc[1] == 8'hC9, "R2 blanking shown", {qa[1], qc[1]}, 8'hC9);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_wide();
        t_mode_mid();
        t_narrow();
        t_back_wide();
      end
      begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule